// File: doc/BRIEF.md
# NAND Page Hamming ECC Engine

This block sits beside a NAND flash data bus and watches every data word that crosses it, 8 or 16 bits at a time. From those words it builds one Hamming code, able to correct a single bit and detect a double, over the whole data area of a page. Commands and addresses on the same bus are filtered out using the command-latch and address-latch qualifiers. Four page sizes are supported, with data areas of 512, 1024, 2048 or 4096 bytes.

When a page is programmed, software reads the 32-bit code from two parity registers and stores it as four check bytes in the spare area. When the page is read back, the four stored check bytes are clocked through the engine straight after the data. The engine XORs them into its computed code. The result is reported as one of four outcomes: clean, correctable data error with its word and bit position, single-bit error inside the check bytes, or uncorrectable. An erased page reads as uncorrectable with every position bit set, so software can recognise it. Correcting the data, DMA and command sequencing are left to the surrounding system.

Top module: `nand_page_ecc`

## Requirements
- R1: The mode register (register index 1) holds the page size in bits 1:0 (0: 512, 1: 1024, 2: 2048, 3: 4096 data bytes) and the bus width in bit 4 (1: 16-bit words, 0: bytes taken from bus bits 7:0). It reads back exactly as written in those bits, with zeros elsewhere.
- R2: Only strobes with both command latch and address latch low are counted or accumulated. Command and address cycles leave the code and the word count unchanged.
- R3: Parity register 0 (index 3) holds, in bits 3:0, the XOR of all data bits whose bit index has that bit set, and in bits 15:4 the XOR of all data bits of words whose word index has that bit set. Parity register 1 (index 4) holds the same sums over indices with the bit clear. Check bytes 0 and 1 are the low and high bytes of register 0. Check bytes 2 and 3 are the low and high bytes of register 1.
- R4: The strobes that follow the page's data words are taken as the stored check value. In 8-bit mode these are four read strobes carrying bytes 0 to 3 on bits 7:0. In 16-bit mode they are two read strobes carrying bytes 0-1, then 2-3, with the low byte in bits 7:0. Once each check strobe has arrived, both parity registers read the computed code XOR the stored value, which is all zeros for a clean page.
- R5: Write strobes after the page data, and any strobe after the last check byte, change neither the parity registers nor the status.
- R6: The status register (index 2) reads zero until the last check byte arrives. After that, bit 0 flags any mismatch, bit 1 a single-bit error in the check bytes, and bit 2 an uncorrectable error.
- R7: When each of the 16 register-0/register-1 bit pairs of the syndrome differs, the status reads 1. Parity register 0 then gives the failing bit in bits 3:0 and the failing word in bits 15:4.
- R8: In 16-bit mode word positions count 16-bit words and the bit position runs 0 to 15.
- R9: A syndrome with exactly one bit set reads status 3.
- R10: Any other non-zero syndrome reads status 5.
- R11: A fully erased page (all data 0xFF, all check bytes 0xFF) reads status 5 with parity register 0 equal to 0xFFFF.
- R12: Writing 1 to bit 0 of the control register (index 0) clears the code, the stored check value, the word count and the status, and restarts the page.
- R13: After synchronous reset all readable registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nand_data | input | 16 | Data seen on the flash bus |
| wr_stb | input | 1 | One-cycle write strobe of a bus cycle |
| rd_stb | input | 1 | One-cycle read strobe of a bus cycle |
| cmd_latch | input | 1 | Bus cycle is a command cycle |
| addr_latch | input | 1 | Bus cycle is an address cycle |
| reg_addr | input | 3 | Register index |
| reg_wen | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |

## Verification
The hardest states to reach from the ports are the ones just before and just after the last check byte, where the status must change from zero to its final value on one exact strobe. A syndrome chosen to land on a specific outcome is just as hard to produce. The bench builds its own reference code from the page contents, then flips chosen data or check bits before the read pass. This places the syndrome on the correctable, check-byte, multiple and erased patterns. The check bytes are fed in two parts so the status can be sampled between them. The largest page is used with an error in its last word and top bit.

// File: rtl/necc_pkg.sv
package necc_pkg;

    localparam int ADDR_W         = 12;
    localparam int BIT_W          = 4;
    localparam int DATA_W         = 1 << BIT_W;
    localparam int HALF_W         = ADDR_W + BIT_W;
    localparam int CODE_W         = 2 * HALF_W;
    localparam int CHK_BYTES      = CODE_W / 8;
    localparam int CHK_IDX_W      = $clog2(CHK_BYTES);
    localparam int CNT_W          = ADDR_W + 1;
    localparam int REG_W          = 32;
    localparam int MIN_PAGE_BYTES = 512;

    typedef enum logic [2:0] {
        REG_CTRL = 3'd0,
        REG_MODE = 3'd1,
        REG_STAT = 3'd2,
        REG_PAR0 = 3'd3,
        REG_PAR1 = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        PH_DATA  = 2'd0,
        PH_CHECK = 2'd1,
        PH_DONE  = 2'd2
    } phase_e;

    // odd: sums over indices with the bit set; even: with the bit clear
    typedef struct packed {
        logic [HALF_W-1:0] odd;
        logic [HALF_W-1:0] even;
    } code_t;

    typedef struct packed {
        logic mul_err;
        logic chk_err;
        logic any_err;
    } flags_t;

    typedef struct packed {
        logic       wide;
        logic [1:0] size_sel;
    } mode_t;

    function automatic logic [CNT_W-1:0] words_in_page(input mode_t m);
        logic [CNT_W-1:0] nbytes;
        nbytes = CNT_W'(MIN_PAGE_BYTES) << m.size_sel;
        return m.wide ? (nbytes >> 1) : nbytes;
    endfunction

    // column parity: for each bit j of the bit index, XOR of the bits whose
    // index has bit j equal to 'upper'
    function automatic logic [BIT_W-1:0] col_parity(input logic [DATA_W-1:0] w,
                                                    input logic upper);
        logic [BIT_W-1:0] p;
        p = '0;
        for (int j = 0; j < BIT_W; j++)
            for (int b = 0; b < DATA_W; b++)
                if ((((b >> j) & 1) != 0) == upper)
                    p[j] = p[j] ^ w[b];
        return p;
    endfunction

    function automatic logic is_single(input logic [CODE_W-1:0] x);
        return (x != '0) && ((x & (x - CODE_W'(1))) == '0);
    endfunction

endpackage

// File: rtl/necc_seq.sv
module necc_seq
    import necc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 wr_stb,
    input  logic                 rd_stb,
    input  logic                 cmd_latch,
    input  logic                 addr_latch,
    input  mode_t                mode,
    output logic                 data_fire,
    output logic                 chk_fire,
    output logic [ADDR_W-1:0]    word_addr,
    output logic [CHK_IDX_W-1:0] chk_idx,
    output logic                 done
);

    phase_e               phase_q;
    logic [ADDR_W-1:0]    cnt_q;
    logic [CHK_IDX_W-1:0] idx_q;
    logic                 bus_data;
    logic [CNT_W-1:0]     last_word;
    logic                 at_last_word;
    logic                 at_last_chk;

    assign bus_data     = !cmd_latch && !addr_latch;
    assign data_fire    = bus_data && (wr_stb || rd_stb) && (phase_q == PH_DATA);
    assign chk_fire     = bus_data && rd_stb && (phase_q == PH_CHECK);
    assign last_word    = words_in_page(mode) - CNT_W'(1);
    assign at_last_word = ({1'b0, cnt_q} == last_word);
    assign at_last_chk  = mode.wide ? (idx_q == CHK_IDX_W'(CHK_BYTES / 2 - 1))
                                    : (idx_q == CHK_IDX_W'(CHK_BYTES - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase_q <= PH_DATA;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else begin
            case (phase_q)
                PH_DATA: begin
                    if (data_fire) begin
                        if (at_last_word) begin
                            phase_q <= PH_CHECK;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + ADDR_W'(1);
                        end
                    end
                end
                PH_CHECK: begin
                    if (chk_fire) begin
                        if (at_last_chk) phase_q <= PH_DONE;
                        else             idx_q   <= idx_q + CHK_IDX_W'(1);
                    end
                end
                default: phase_q <= PH_DONE;
            endcase
        end
    end

    assign word_addr = cnt_q;
    assign chk_idx   = idx_q;
    assign done      = (phase_q == PH_DONE);

    // R5: a finished page stays finished until cleared
    assert_done_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (done && !clr) |=> done);

    // R4: once the check phase is entered, data counting never resumes without a clear
    assert_check_order_R4: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_CHECK && !clr) |=> (phase_q != PH_DATA));

endmodule

// File: rtl/necc_accum.sv
module necc_accum
    import necc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              fire,
    input  logic [ADDR_W-1:0] word_addr,
    input  logic [DATA_W-1:0] data,
    output code_t             code
);

    code_t code_q;
    code_t code_d;
    logic  row_par;

    assign row_par = ^data;

    always_comb begin
        code_d = code_q;
        if (fire) begin
            code_d.odd[BIT_W-1:0]  = code_q.odd[BIT_W-1:0]  ^ col_parity(data, 1'b1);
            code_d.even[BIT_W-1:0] = code_q.even[BIT_W-1:0] ^ col_parity(data, 1'b0);
            for (int i = 0; i < ADDR_W; i++) begin
                if (word_addr[i])
                    code_d.odd[BIT_W+i]  = code_q.odd[BIT_W+i]  ^ row_par;
                else
                    code_d.even[BIT_W+i] = code_q.even[BIT_W+i] ^ row_par;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) code_q <= '0;
        else            code_q <= code_d;
    end

    assign code = code_q;

    // R2: without a qualified data strobe the code does not move
    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (!fire && !clr) |=> $stable(code_q));

    // R12: a clear request empties the code on the next cycle
    assert_clear_code_R12: assert property (@(posedge clk) disable iff (rst)
        clr |=> (code_q == '0));

endmodule

// File: rtl/necc_check.sv
module necc_check
    import necc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 chk_fire,
    input  logic [CHK_IDX_W-1:0] chk_idx,
    input  logic                 wide,
    input  logic [DATA_W-1:0]    data,
    input  code_t                code,
    input  logic                 done,
    output code_t                syndrome,
    output flags_t               flags
);

    logic [CODE_W-1:0] stored_q;
    logic              correctable;
    logic              single;
    logic              nonzero;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            stored_q <= '0;
        end else if (chk_fire) begin
            if (wide) stored_q[int'(chk_idx[0]) * DATA_W +: DATA_W] <= data;
            else      stored_q[int'(chk_idx) * 8 +: 8]              <= data[7:0];
        end
    end

    // stored bytes 0..1 line up with the odd half, bytes 2..3 with the even half
    assign syndrome.odd  = code.odd  ^ stored_q[HALF_W-1:0];
    assign syndrome.even = code.even ^ stored_q[CODE_W-1:HALF_W];

    assign nonzero     = (syndrome != '0);
    assign single      = is_single(syndrome);
    assign correctable = ((syndrome.odd ^ syndrome.even) == '1);

    always_comb begin
        flags = '0;
        if (done) begin
            flags.any_err = nonzero;
            flags.chk_err = single;
            flags.mul_err = nonzero && !single && !correctable;
        end
    end

    // R5: the stored check value changes only on an accepted check strobe
    assert_stored_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!chk_fire && !clr) |=> $stable(stored_q));

    // R6: once reported, the outcome stays put until a clear
    assert_flags_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (done && !clr) |=> $stable(flags));

endmodule

// File: rtl/nand_page_ecc.sv
module nand_page_ecc
    import necc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [15:0]      nand_data,
    input  logic             wr_stb,
    input  logic             rd_stb,
    input  logic             cmd_latch,
    input  logic             addr_latch,
    input  logic [2:0]       reg_addr,
    input  logic             reg_wen,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata
);

    mode_t                mode_q;
    logic                 clr;
    logic [DATA_W-1:0]    bus_word;
    logic                 data_fire;
    logic                 chk_fire;
    logic [ADDR_W-1:0]    word_addr;
    logic [CHK_IDX_W-1:0] chk_idx;
    logic                 done;
    code_t                code;
    code_t                syndrome;
    flags_t               flags;
    logic                 unused_wdata_bits;

    assign unused_wdata_bits = ^{reg_wdata[REG_W-1:5], reg_wdata[3:2]};

    assign clr = reg_wen && (reg_addr == REG_CTRL) && reg_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (reg_wen && (reg_addr == REG_MODE)) begin
            mode_q.wide     <= reg_wdata[4];
            mode_q.size_sel <= reg_wdata[1:0];
        end
    end

    // narrow bus: only the low byte carries data
    assign bus_word = mode_q.wide ? nand_data
                                  : {{(DATA_W/2){1'b0}}, nand_data[DATA_W/2-1:0]};

    necc_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .wr_stb     (wr_stb),
        .rd_stb     (rd_stb),
        .cmd_latch  (cmd_latch),
        .addr_latch (addr_latch),
        .mode       (mode_q),
        .data_fire  (data_fire),
        .chk_fire   (chk_fire),
        .word_addr  (word_addr),
        .chk_idx    (chk_idx),
        .done       (done)
    );

    necc_accum u_accum (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .fire      (data_fire),
        .word_addr (word_addr),
        .data      (bus_word),
        .code      (code)
    );

    necc_check u_check (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .chk_fire (chk_fire),
        .chk_idx  (chk_idx),
        .wide     (mode_q.wide),
        .data     (bus_word),
        .code     (code),
        .done     (done),
        .syndrome (syndrome),
        .flags    (flags)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_MODE: begin
                reg_rdata[4]   = mode_q.wide;
                reg_rdata[1:0] = mode_q.size_sel;
            end
            REG_STAT: reg_rdata[2:0]        = flags;
            REG_PAR0: reg_rdata[HALF_W-1:0] = syndrome.odd;
            REG_PAR1: reg_rdata[HALF_W-1:0] = syndrome.even;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: tb/nand_page_ecc_tb.sv
module nand_page_ecc_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] nand_data = '0;
    logic        wr_stb = 1'b0;
    logic        rd_stb = 1'b0;
    logic        cmd_latch = 1'b0;
    logic        addr_latch = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [15:0] pg [0:4095];

    always #4 clk = ~clk;

    nand_page_ecc u_dut (
        .clk        (clk),
        .rst        (rst),
        .nand_data  (nand_data),
        .wr_stb     (wr_stb),
        .rd_stb     (rd_stb),
        .cmd_latch  (cmd_latch),
        .addr_latch (addr_latch),
        .reg_addr   (reg_addr),
        .reg_wen    (reg_wen),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic strobe(input logic [15:0] d, input bit rd, input bit cl, input bit al);
        @(negedge clk);
        nand_data = d; rd_stb = rd; wr_stb = !rd; cmd_latch = cl; addr_latch = al;
        @(negedge clk);
        rd_stb = 0; wr_stb = 0; cmd_latch = 0; addr_latch = 0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wen = 1;
        @(negedge clk);
        reg_wen = 0; reg_wdata = '0;
    endtask

    task automatic set_mode(input int sel, input bit wide);
        wreg(3'd1, {27'd0, wide, 2'b00, 2'(sel)});
        wreg(3'd0, 32'd1);
    endtask

    task automatic fill(input int seed, input int n);
        for (int i = 0; i < n; i++)
            pg[i] = 16'((i * 40503 + seed * 7919) ^ (i << 5));
    endtask

    // reference code straight from the definition; returns {reg1, reg0}
    function automatic logic [31:0] model(input int n, input bit wide);
        logic [15:0] odd, even, d;
        odd = '0; even = '0;
        for (int w = 0; w < n; w++) begin
            d = wide ? pg[w] : {8'h00, pg[w][7:0]};
            for (int b = 0; b < 16; b++) begin
                if (d[b]) begin
                    for (int j = 0; j < 4; j++)
                        if (((b >> j) & 1) != 0) odd[j] = ~odd[j]; else even[j] = ~even[j];
                    for (int i = 0; i < 12; i++)
                        if (((w >> i) & 1) != 0) odd[4+i] = ~odd[4+i]; else even[4+i] = ~even[4+i];
                end
            end
        end
        return {even, odd};
    endfunction

    task automatic feed_page(input int n, input bit rd);
        strobe(16'h0000, 0, 1, 0);
        strobe(16'h0012, 0, 0, 1);
        strobe(16'h0034, 0, 0, 1);
        for (int w = 0; w < n; w++) begin
            if (w == n / 2) begin
                strobe(16'h5a5a, 0, 1, 0);
                strobe(16'ha5a5, 0, 0, 1);
            end
            strobe(pg[w], rd, 0, 0);
        end
    endtask

    task automatic feed_check(input logic [31:0] s, input bit wide, input int from, input int upto);
        for (int k = from; k < upto; k++) begin
            if (wide) strobe(s[k*16 +: 16], 1, 0, 0);
            else      strobe({8'hc3, s[k*8 +: 8]}, 1, 0, 0);
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rreg(3'd2, v); check("R13", "status after reset", v, 0);
        rreg(3'd3, v); check("R13", "parity0 after reset", v, 0);
        rreg(3'd4, v); check("R13", "parity1 after reset", v, 0);
        rreg(3'd1, v); check("R13", "mode after reset", v, 0);
    endtask

    task automatic t_write_code();
        logic [31:0] v, e;
        set_mode(0, 0);
        rreg(3'd1, v); check("R1", "mode readback 512/8", v, 0);
        strobe(16'h00ff, 0, 1, 0);
        strobe(16'h00ee, 0, 0, 1);
        strobe(16'h00dd, 1, 0, 1);
        rreg(3'd3, v); check("R2", "parity0 after cmd/addr only", v, 0);
        rreg(3'd4, v); check("R2", "parity1 after cmd/addr only", v, 0);
        wreg(3'd0, 32'd1);
        fill(1, 512);
        feed_page(512, 0);
        e = model(512, 0);
        rreg(3'd3, v); check("R3", "write code parity0", v, {16'd0, e[15:0]});
        rreg(3'd4, v); check("R3", "write code parity1", v, {16'd0, e[31:16]});
        for (int k = 0; k < 4; k++) strobe(16'h1111 * 16'(k + 1), 0, 0, 0);
        rreg(3'd3, v); check("R5", "parity0 after spare writes", v, {16'd0, e[15:0]});
        rreg(3'd2, v); check("R5", "status after spare writes", v, 0);
    endtask

    task automatic t_read_clean();
        logic [31:0] v, e;
        set_mode(0, 0);
        fill(1, 512);
        e = model(512, 0);
        feed_page(512, 1);
        feed_check(e, 0, 0, 4);
        rreg(3'd2, v); check("R4", "clean page status", v, 0);
        rreg(3'd3, v); check("R4", "clean page parity0", v, 0);
        rreg(3'd4, v); check("R4", "clean page parity1", v, 0);
    endtask

    task automatic t_single_byte();
        logic [31:0] v, e;
        set_mode(0, 0);
        fill(2, 512);
        e = model(512, 0);
        pg[300][5] = ~pg[300][5];
        feed_page(512, 1);
        feed_check(e, 0, 0, 3);
        rreg(3'd2, v); check("R6", "status before last check byte", v, 0);
        feed_check(e, 0, 3, 4);
        rreg(3'd2, v); check("R7", "single data error status", v, 1);
        rreg(3'd3, v); check("R7", "error position word 300 bit 5", v, 32'h12c5);
        for (int k = 0; k < 3; k++) strobe(16'h0f0f, 1, 0, 0);
        strobe(16'h7777, 0, 0, 0);
        rreg(3'd2, v); check("R5", "status after trailing strobes", v, 1);
        rreg(3'd3, v); check("R5", "position after trailing strobes", v, 32'h12c5);
    endtask

    task automatic t_wide();
        logic [31:0] v, e;
        set_mode(1, 1);
        rreg(3'd1, v); check("R1", "mode readback 1024/16", v, 32'h11);
        fill(3, 512);
        e = model(512, 1);
        pg[511][13] = ~pg[511][13];
        feed_page(512, 1);
        feed_check(e, 1, 0, 1);
        rreg(3'd2, v); check("R6", "wide status before last check word", v, 0);
        feed_check(e, 1, 1, 2);
        rreg(3'd2, v); check("R8", "wide single error status", v, 1);
        rreg(3'd3, v); check("R8", "wide position word 511 bit 13", v, 32'h1ffd);
    endtask

    task automatic t_check_byte();
        logic [31:0] v, e;
        set_mode(0, 0);
        fill(4, 512);
        e = model(512, 0);
        feed_page(512, 1);
        feed_check(e ^ 32'h0010_0000, 0, 0, 4);
        rreg(3'd2, v); check("R9", "check byte error status", v, 3);
        rreg(3'd4, v); check("R9", "check byte syndrome parity1", v, 32'h10);
    endtask

    task automatic t_multi();
        logic [31:0] v, e;
        set_mode(0, 0);
        fill(5, 512);
        e = model(512, 0);
        pg[10][1] = ~pg[10][1];
        pg[77][6] = ~pg[77][6];
        feed_page(512, 1);
        feed_check(e, 0, 0, 4);
        rreg(3'd2, v); check("R10", "double data error status", v, 5);
    endtask

    task automatic t_erased();
        logic [31:0] v;
        set_mode(2, 0);
        for (int i = 0; i < 2048; i++) pg[i] = 16'hffff;
        feed_page(2048, 1);
        feed_check(32'hffff_ffff, 0, 0, 4);
        rreg(3'd2, v); check("R11", "erased page status", v, 5);
        rreg(3'd3, v); check("R11", "erased page position", v, 32'hffff);
    endtask

    task automatic t_soft_clear();
        logic [31:0] v, e;
        wreg(3'd1, 32'd0);
        wreg(3'd0, 32'd1);
        rreg(3'd2, v); check("R12", "status cleared", v, 0);
        fill(6, 512);
        for (int w = 0; w < 100; w++) strobe(16'h3c00 ^ 16'(w), 0, 0, 0);
        wreg(3'd0, 32'd1);
        rreg(3'd3, v); check("R12", "parity0 cleared mid page", v, 0);
        rreg(3'd4, v); check("R12", "parity1 cleared mid page", v, 0);
        feed_page(512, 0);
        e = model(512, 0);
        rreg(3'd3, v); check("R12", "code after restart parity0", v, {16'd0, e[15:0]});
        rreg(3'd4, v); check("R12", "code after restart parity1", v, {16'd0, e[31:16]});
    endtask

    task automatic t_largest();
        logic [31:0] v, e;
        set_mode(3, 0);
        rreg(3'd1, v); check("R1", "mode readback 4096/8", v, 32'h3);
        fill(7, 4096);
        e = model(4096, 0);
        pg[4095][7] = ~pg[4095][7];
        feed_page(4096, 1);
        feed_check(e, 0, 0, 4);
        rreg(3'd2, v); check("R7", "largest page single error status", v, 1);
        rreg(3'd3, v); check("R7", "position last word top bit", v, 32'hfff7);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_write_code();
        t_read_clean();
        t_single_byte();
        t_wide();
        t_check_byte();
        t_multi();
        t_erased();
        t_soft_clear();
        t_largest();
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule